// File: doc/BRIEF.md
# Core Timer with Real-Time Interrupt

A free-running timebase for a small microcontroller. A single synchronous binary chain, advanced by one on every system clock, serves as prescaler, 8-bit overflow counter and the divider stages that follow it. Each divider tap is a one-cycle enable pulse, with no derived clocks. When the overflow counter wraps, a timer-overflow flag is set. Two further stages give a reset-timing tap. Two more stages give the real-time interrupt (RTI) input. From that input, a three-stage divider with a 1-of-4 selector produces the RTI tick. The selected tick is divided by eight to give a tick for an external watchdog.

Software sees one status/control byte through a select/write-enable port, and reads from it are combinational:

| Bit | Read | Write |
|-----|------|-------|
| 7 | overflow flag | ignored |
| 6 | RTI flag | ignored |
| 5 | overflow enable | overflow enable |
| 4 | RTI enable | RTI enable |
| 3 | 0 | 1 clears the overflow flag |
| 2 | 0 | 1 clears the RTI flag |
| 1:0 | rate code | rate code |

The interrupt request is a level. It stays high while an enabled flag remains set.

Top module: `core_timer`

## Requirements
- R1: After reset the register reads 0x03 (flags 0, enables 0, rate code 11) and irq_o is 0.
- R2: The overflow flag (bit 7) sets once every 2^(PRE_W+CNT_W) clocks (1024 with the defaults).
- R3: The RTI flag (bit 6) sets once every 2^(PRE_W+CNT_W+RST_ST+RTI_ST+code) clocks. Rate code 00, 01, 10 and 11 divide the RTI input by 1, 2, 4 and 8.
- R4: A write with bit 3 = 1 clears the overflow flag, and a write with bit 2 = 1 clears the RTI flag. A write with 0 in either bit leaves that flag unchanged.
- R5: When a flag's set event and its clear write fall in the same clock, the flag ends up set.
- R6: irq_o = (bit 7 and bit 5) or (bit 6 and bit 4). It is a level and drops only when the flag or its enable is cleared.
- R7: Bits 3 and 2 always read 0, and writes to bits 7 and 6 do not change the flags.
- R8: rst_tap_o pulses for one clock every 2^(PRE_W+CNT_W+RST_ST) clocks.
- R9: wdog_tick_o pulses for one clock every 8 selected RTI periods.
- R10: Bits 5, 4 and 1:0 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write enable, qualified by sel_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request level |
| wdog_tick_o | output | 1 | One-clock watchdog tick |
| rst_tap_o | output | 1 | One-clock reset-timing tap |

## Verification
The hardest case to reach is a clear write that lands in exactly the clock in which the counter sets the same flag. The bench first observes a set of the overflow flag. It then counts one overflow period less one clock from that point and issues the clear, so that the write coincides with the next set event. The long divider intervals are measured between two consecutive observed flag sets, with the flag cleared in between. A smaller chain parameterisation keeps every rate code and the watchdog tick within the run.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_TOF   = 7;
  localparam int unsigned B_RTIF  = 6;
  localparam int unsigned B_TOFE  = 5;
  localparam int unsigned B_RTIE  = 4;
  localparam int unsigned B_CTOF  = 3;
  localparam int unsigned B_CRTI  = 2;
  localparam int unsigned RATE_W  = 2;
  typedef logic [RATE_W-1:0] rate_t;
  localparam rate_t RATE_RST = 2'b11;
endpackage

// File: rtl/ct_divchain.sv
module ct_divchain #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W:0]   carry_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // carry_o[k] pulses once every 2^k clocks
  assign carry_o[0] = 1'b1;
  for (genvar k = 0; k < W; k++) begin : g_carry
    assign carry_o[k+1] = carry_o[k] & cnt_q[k];
  end

  a_r2_carry_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o[1] |=> !carry_o[1]);
  a_r8_carry_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o[W] |-> carry_o[1]);
endmodule

// File: rtl/ct_rate_sel.sv
module ct_rate_sel #(
  parameter int unsigned W       = 20,
  parameter int unsigned RTI_POS = 14,
  parameter int unsigned WDOG_W  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W:0]     carry_i,
  input  ct_pkg::rate_t  rate_i,
  output logic           rti_tick_o,
  output logic           wdog_tick_o
);
  localparam int unsigned NSEL = 1 << ct_pkg::RATE_W;
  logic [NSEL-1:0] rti_opt, wdog_opt;

  for (genvar i = 0; i < NSEL; i++) begin : g_opt
    assign rti_opt[i]  = carry_i[RTI_POS + i];
    assign wdog_opt[i] = carry_i[RTI_POS + i + WDOG_W];
  end

  assign rti_tick_o  = rti_opt[rate_i];
  assign wdog_tick_o = wdog_opt[rate_i];

  a_r9_wdog_on_rti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_tick_o |-> rti_tick_o);
endmodule

// File: rtl/ct_flag.sv
module ct_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              ovf_tick_i,
  input  logic              rti_tick_i,
  output logic [REG_W-1:0]  rdata_o,
  output rate_t             rate_o,
  output logic              irq_o
);
  logic wr;
  logic tofe_q, rtie_q, tof, rtif;
  rate_t rate_q;

  assign wr = sel_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tofe_q <= 1'b0;
      rtie_q <= 1'b0;
      rate_q <= RATE_RST;
    end else if (wr) begin
      tofe_q <= wdata_i[B_TOFE];
      rtie_q <= wdata_i[B_RTIE];
      rate_q <= wdata_i[RATE_W-1:0];
    end
  end

  ct_flag u_tof (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (ovf_tick_i), .clr_i (wr & wdata_i[B_CTOF]), .flag_o (tof)
  );

  ct_flag u_rtif (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (rti_tick_i), .clr_i (wr & wdata_i[B_CRTI]), .flag_o (rtif)
  );

  always_comb begin
    rdata_o          = '0;
    rdata_o[B_TOF]   = tof;
    rdata_o[B_RTIF]  = rtif;
    rdata_o[B_TOFE]  = tofe_q;
    rdata_o[B_RTIE]  = rtie_q;
    rdata_o[RATE_W-1:0] = rate_q;
  end

  assign rate_o = rate_q;
  assign irq_o  = (tof & tofe_q) | (rtif & rtie_q);

  a_r6_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[B_TOF] || rdata_o[B_RTIF]));
  a_r10_rate_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (rate_o == $past(wdata_i[RATE_W-1:0])));
  a_r7_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[B_CTOF:B_CRTI] == 2'b00);
endmodule

// File: rtl/core_timer.sv
module core_timer
  import ct_pkg::*;
#(
  parameter int unsigned PRE_W   = 2,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_ST  = 2,
  parameter int unsigned RTI_ST  = 2,
  parameter int unsigned RTI_DIV = 3,
  parameter int unsigned WDOG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              wdog_tick_o,
  output logic              rst_tap_o
);
  localparam int unsigned OVF_POS = PRE_W + CNT_W;
  localparam int unsigned TAP_POS = OVF_POS + RST_ST;
  localparam int unsigned RTI_POS = TAP_POS + RTI_ST;
  localparam int unsigned CHAIN_W = RTI_POS + RTI_DIV + WDOG_W;

  logic [CHAIN_W:0] carry;
  logic  rti_tick;
  rate_t rate;

  ct_divchain #(.W(CHAIN_W)) u_chain (
    .clk_i (clk_i), .rst_ni (rst_ni), .carry_o (carry)
  );

  ct_rate_sel #(.W(CHAIN_W), .RTI_POS(RTI_POS), .WDOG_W(WDOG_W)) u_sel (
    .clk_i (clk_i), .rst_ni (rst_ni), .carry_i (carry), .rate_i (rate),
    .rti_tick_o (rti_tick), .wdog_tick_o (wdog_tick_o)
  );

  ct_regs u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel_i), .we_i (we_i),
    .wdata_i (wdata_i), .ovf_tick_i (carry[OVF_POS]), .rti_tick_i (rti_tick),
    .rdata_o (rdata_o), .rate_o (rate), .irq_o (irq_o)
  );

  assign rst_tap_o = carry[TAP_POS];

  a_r8_tap_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_tap_o |-> carry[OVF_POS]);
endmodule

// File: tb/tb_core_timer.sv
module tb_core_timer;
  localparam int unsigned PRE_W = 1;
  localparam int unsigned CNT_W = 4;
  localparam int OVF_P = 1 << (PRE_W + CNT_W);
  localparam int TAP_P = OVF_P * 4;
  localparam int RTI_P = OVF_P * 16;

  logic clk = 1'b0, rst_ni = 1'b0, sel = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, wdog, tap;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .sel_i (sel), .we_i (we), .wdata_i (wdata),
    .rdata_o (rdata), .irq_o (irq), .wdog_tick_o (wdog), .rst_tap_o (tap)
  );

  typedef struct packed { logic [1:0] code; int unsigned period; } rvec_t;
  localparam rvec_t RVEC [4] = '{
    '{2'b00, RTI_P}, '{2'b01, RTI_P*2}, '{2'b10, RTI_P*4}, '{2'b11, RTI_P*8}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller is at a negedge; write is taken at the following posedge
  task automatic wr(logic [7:0] d);
    sel = 1'b1; we = 1'b1; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic wait_bit(int b, output int t);
    int n = 0;
    while (!rdata[b] && n < 70000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic flag_period(int b, logic [7:0] ctl, output int p);
    int t1, t2;
    wait_bit(b, t1);
    wr(ctl | 8'h0C);
    wait_bit(b, t2);
    p = t2 - t1;
  endtask

  function automatic logic sig(int w);
    return (w == 0) ? tap : wdog;
  endfunction

  task automatic pulse_period(int w, output int p);
    int t1, n = 0;
    while (!sig(w) && n < 70000) begin @(negedge clk); n++; end
    t1 = cyc;
    @(negedge clk);
    chk("R8/R9 pulse width", int'(sig(w)), 0);
    n = 0;
    while (!sig(w) && n < 70000) begin @(negedge clk); n++; end
    p = cyc - t1;
  endtask

  initial begin
    int p, t;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset value", int'(rdata), 8'h03);
    chk("R1 irq reset", int'(irq), 0);

    flag_period(7, 8'h03, p);
    chk("R2 overflow period", p, OVF_P);

    pulse_period(0, p);
    chk("R8 reset tap period", p, TAP_P);

    for (int i = 0; i < 4; i++) begin
      wr({6'b000011, RVEC[i].code});
      flag_period(6, {6'b000000, RVEC[i].code}, p);
      chk($sformatf("R3 rti period code %0d", RVEC[i].code), p, int'(RVEC[i].period));
      if (i == 0 || i == 3) begin
        pulse_period(1, p);
        chk($sformatf("R9 wdog period code %0d", RVEC[i].code), p, int'(RVEC[i].period) * 8);
      end
    end

    // R10 read back of enables and rate
    wr(8'h02);
    chk("R10 read back", int'(rdata & 8'h33), 8'h02);
    wr(8'h31);
    chk("R10 read back", int'(rdata & 8'h33), 8'h31);

    // R4 zero write leaves flag; R6 irq level
    wr(8'h31);
    wait_bit(7, t);
    @(negedge clk);
    chk("R6 irq on tof", int'(irq), 1);
    wr(8'h31);
    chk("R4 zero write keeps tof", int'(rdata[7]), 1);
    chk("R6 irq held", int'(irq), 1);
    wr(8'h11);
    chk("R6 irq off when tofe 0", int'(irq), int'(rdata[6]));
    wr(8'h19);
    chk("R4 clear tof", int'(rdata[7]), 0);

    // R7 ignored writes to flag bits, bits 3:2 read zero
    wr(8'h0D);
    wait_bit(7, t);
    wr(8'hCD);
    chk("R7 flag write ignored and zero bits", int'(rdata & 8'h8C), 0);

    // R5 clear coincides with next set
    wr(8'h01);
    wait_bit(7, t);
    repeat (OVF_P - 1 - (cyc - t)) @(negedge clk);
    wr(8'h09);
    chk("R5 set wins", int'(rdata[7]), 1);

    // R6 irq from rti
    wr(8'h1C);
    wait_bit(6, t);
    @(negedge clk);
    chk("R6 irq on rtif", int'(irq), 1);
    wr(8'h14);
    chk("R6 irq drop on clear", int'(irq), 0);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 190000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule